// File: doc/BRIEF.md
# Pin-Configured Conversion Settling Sequencer

This block holds the digital timing control of a slow converter whose setup comes from two static pins. One pin picks the filter and therefore the update rate. The other pin picks the front-end gain. The block counts conversion periods in clock ticks and raises a one-clock event at the end of each period. At each event it loads a data register from a sample bus, which stands in for the modulator and filter arithmetic.

After reset, and after any change on either pin, the filter needs several whole periods to settle. During that time every conversion still loads the register, but none is flagged valid. The number of periods depends on the filter in use. A single active-low line carries both the ready flag and the serial data. It stays high while no settled result is pending. Once a settled result is ready it drops low, and read strobes then walk the result out on it, most significant bit first.

Top module: `pin_cfg_settle_seq`

## Requirements
- R1: During and right after reset, `rdy_dout` is 1, `data_valid` and `conv_done` are 0 and `data_out` is all zeros.
- R2: With `filt_sel_pin` low, conversions end every FAST_TICKS clocks. With it high, they end every SLOW_TICKS clocks. After the first valid result, `conv_done` and `data_valid` both pulse exactly one period later.
- R3: With the slow filter (pin high), the first `data_valid` after a restart comes SLOW_SETTLE (3) periods after the restart. This is 3 + 3·SLOW_TICKS clocks after the pin edge is applied.
- R4: With the fast filter (pin low), the first `data_valid` after a restart or after reset comes FAST_SETTLE (2) periods later. This is 3 + 2·FAST_TICKS clocks after a pin edge, or 2·FAST_TICKS clocks after reset is released.
- R5: An edge on `filt_sel_pin`, seen after the two-flop synchronizer, restarts the period timing at once. `rdy_dout` is 1 from the third clock after the edge is applied.
- R6: An edge on `gain_sel_pin`, in either direction, causes the same restart and the same full settling delay as a filter edge.
- R7: `gain_unity` reports the synchronized gain pin: 1 means gain 1 (pin high) and 0 means gain 128 (pin low). It follows the pin within three clocks.
- R8: Every conversion event, including those during settling, pulses `conv_done` for one clock and loads `data_out` with the `sample_in` value present at that edge. Only the events after the settling count also raise `data_valid`.
- R9: `data_valid` is one clock wide. `rdy_dout` goes low together with it and returns high one clock before the next conversion event, after the period minus one clocks.
- R10: While no settled result is pending (including the whole settling time after a pin change), `rdy_dout` stays 1 and read strobes on `rd_bit` return only ones.
- R11: While a result is pending, `rdy_dout` is 0 until the first `rd_bit` strobe. Strobe k (k = 1..DATA_W) then puts bit DATA_W−k of `data_out` on `rd_bit`'s output line `rdy_dout`, so the most significant bit comes first.
- R12: A pin edge during a settling period restarts the settling count from zero. No `data_valid` comes before the full settling time measured from the later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filt_sel_pin | input | 1 | Filter select, asynchronous; low = fast rate, high = slow rate |
| gain_sel_pin | input | 1 | Gain select, asynchronous; low = gain 128, high = gain 1 |
| sample_in | input | DATA_W | Stand-in conversion result |
| rd_bit | input | 1 | Serial read strobe, one bit per clock it is high |
| rdy_dout | output | 1 | Active-low ready flag combined with serial data |
| conv_done | output | 1 | One-clock pulse at each conversion event |
| data_valid | output | 1 | One-clock pulse at each settled conversion |
| data_out | output | DATA_W | Data register |
| gain_unity | output | 1 | Active gain status, 1 = gain 1 |

## Verification
A wrong period or settle count moves the first `data_valid` after a pin edge by whole periods. A missed or spurious restart shows as `rdy_dout` staying low at the third clock after the edge, or as a valid pulse arriving early. A wrong bit index or a wrong ready window shows up within one period: in the serial bits of a freshly loaded result, or in the clock where `rdy_dout` returns high. The bench sweeps both filters across both edge directions of both pins and predicts each pulse cycle from the period arithmetic.

// File: rtl/cfgsq_pkg.sv
package cfgsq_pkg;

  typedef struct packed {
    logic filt_slow;
    logic gain_unity;
  } cfg_t;

  function automatic int unsigned period_for(input logic slow,
                                             input int unsigned fast_p,
                                             input int unsigned slow_p);
    return slow ? slow_p : fast_p;
  endfunction

  function automatic int unsigned settle_for(input logic slow,
                                             input int unsigned fast_n,
                                             input int unsigned slow_n);
    return slow ? slow_n : fast_n;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cfgsq_sync.sv
module cfgsq_sync #(
  parameter int unsigned N_PINS = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_raw,
  output logic [N_PINS-1:0] pin_sync,
  output logic [N_PINS-1:0] pin_chg
);

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    // pipe[STAGES-1] is the synchronized value, pipe[STAGES] its history
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-1:0], pin_raw[i]};
    end

    assign pin_sync[i] = pipe[STAGES-1];
    assign pin_chg[i]  = pipe[STAGES-1] ^ pipe[STAGES];
  end

endmodule

// File: rtl/cfgsq_timer.sv
module cfgsq_timer
  import cfgsq_pkg::*;
#(
  parameter int unsigned FAST_TICKS  = 60,
  parameter int unsigned SLOW_TICKS  = 100,
  parameter int unsigned FAST_SETTLE = 2,
  parameter int unsigned SLOW_SETTLE = 3,
  parameter int unsigned TICK_W      = 7,
  parameter int unsigned SET_W       = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow,
  input  logic restart,
  output logic conv_evt,
  output logic conv_ok,
  output logic near_end
);

  logic [TICK_W-1:0] tick_q, last_tick, warn_tick;
  logic [SET_W-1:0]  set_q, last_set;

  always_comb begin
    last_tick = TICK_W'(period_for(slow, FAST_TICKS, SLOW_TICKS) - 1);
    warn_tick = TICK_W'(period_for(slow, FAST_TICKS, SLOW_TICKS) - 2);
    last_set  = SET_W'(settle_for(slow, FAST_SETTLE, SLOW_SETTLE) - 1);
  end

  assign conv_evt = !restart && (tick_q == last_tick);
  assign near_end = !restart && (tick_q == warn_tick);
  assign conv_ok  = conv_evt && (set_q == last_set);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      tick_q <= '0;
      set_q  <= '0;
    end else if (conv_evt) begin
      tick_q <= '0;
      if (set_q != last_set) set_q <= set_q + 1'b1;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

endmodule

// File: rtl/cfgsq_out.sv
module cfgsq_out #(
  parameter int unsigned DATA_W = 20,
  parameter int unsigned BIT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              conv_evt,
  input  logic              conv_ok,
  input  logic              near_end,
  input  logic [DATA_W-1:0] sample_in,
  input  logic              rd_bit,
  output logic              conv_done,
  output logic              data_valid,
  output logic [DATA_W-1:0] data_out,
  output logic              avail,
  output logic              rdy_dout
);

  logic [BIT_W-1:0] bit_cnt;
  logic [BIT_W-1:0] bit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_done  <= 1'b0;
      data_valid <= 1'b0;
      data_out   <= '0;
    end else begin
      conv_done  <= conv_evt;
      data_valid <= conv_ok;
      if (conv_evt) data_out <= sample_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) avail <= 1'b0;
    else if (conv_ok)      avail <= 1'b1;
    else if (near_end)     avail <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart || conv_evt)
      bit_cnt <= '0;
    else if (rd_bit && avail && bit_cnt != BIT_W'(DATA_W))
      bit_cnt <= bit_cnt + 1'b1;
  end

  assign bit_idx = BIT_W'(DATA_W) - bit_cnt;

  always_comb begin
    if (!avail)             rdy_dout = 1'b1;
    else if (bit_cnt == '0) rdy_dout = 1'b0;
    else                    rdy_dout = data_out[bit_idx];
  end

endmodule

// File: rtl/pin_cfg_settle_seq.sv
module pin_cfg_settle_seq
  import cfgsq_pkg::*;
#(
  parameter int unsigned DATA_W      = 20,
  parameter int unsigned FAST_TICKS  = 60,
  parameter int unsigned SLOW_TICKS  = 100,
  parameter int unsigned FAST_SETTLE = 2,
  parameter int unsigned SLOW_SETTLE = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              filt_sel_pin,
  input  logic              gain_sel_pin,
  input  logic [DATA_W-1:0] sample_in,
  input  logic              rd_bit,
  output logic              rdy_dout,
  output logic              conv_done,
  output logic              data_valid,
  output logic [DATA_W-1:0] data_out,
  output logic              gain_unity
);

  localparam int unsigned MAX_TICKS  = max_of(FAST_TICKS, SLOW_TICKS);
  localparam int unsigned MAX_SETTLE = max_of(FAST_SETTLE, SLOW_SETTLE);
  localparam int unsigned TICK_W     = $clog2(MAX_TICKS);
  localparam int unsigned SET_W      = $clog2(MAX_SETTLE + 1);
  localparam int unsigned BIT_W      = $clog2(DATA_W + 1);
  localparam int unsigned N_PINS     = 2;

  logic [N_PINS-1:0] pin_raw, pin_sync, pin_chg;
  cfg_t              cfg;
  logic              restart;
  logic              conv_evt;
  logic              conv_ok;
  logic              near_end;
  logic              avail;

  assign pin_raw = {gain_sel_pin, filt_sel_pin};

  cfgsq_sync #(
    .N_PINS (N_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_raw  (pin_raw),
    .pin_sync (pin_sync),
    .pin_chg  (pin_chg)
  );

  assign cfg     = '{filt_slow: pin_sync[0], gain_unity: pin_sync[1]};
  assign restart = |pin_chg;

  cfgsq_timer #(
    .FAST_TICKS  (FAST_TICKS),
    .SLOW_TICKS  (SLOW_TICKS),
    .FAST_SETTLE (FAST_SETTLE),
    .SLOW_SETTLE (SLOW_SETTLE),
    .TICK_W      (TICK_W),
    .SET_W       (SET_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow     (cfg.filt_slow),
    .restart  (restart),
    .conv_evt (conv_evt),
    .conv_ok  (conv_ok),
    .near_end (near_end)
  );

  cfgsq_out #(
    .DATA_W (DATA_W),
    .BIT_W  (BIT_W)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .conv_evt   (conv_evt),
    .conv_ok    (conv_ok),
    .near_end   (near_end),
    .sample_in  (sample_in),
    .rd_bit     (rd_bit),
    .conv_done  (conv_done),
    .data_valid (data_valid),
    .data_out   (data_out),
    .avail      (avail),
    .rdy_dout   (rdy_dout)
  );

  assign gain_unity = cfg.gain_unity;

endmodule

// File: rtl/pin_cfg_settle_seq_chk.sv
module pin_cfg_settle_seq_chk #(
  parameter int unsigned DATA_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restart,
  input logic              conv_done,
  input logic              data_valid,
  input logic              rdy_dout,
  input logic [DATA_W-1:0] data_out,
  input logic [DATA_W-1:0] sample_in
);

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);

  // R9
  valid_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> !rdy_dout);

  // R5
  restart_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> rdy_dout);

  // R8
  valid_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> conv_done);

  // R8
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_done) |-> data_out == $past(sample_in));

  // R8
  conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);

endmodule

bind pin_cfg_settle_seq pin_cfg_settle_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .restart    (restart),
  .conv_done  (conv_done),
  .data_valid (data_valid),
  .rdy_dout   (rdy_dout),
  .data_out   (data_out),
  .sample_in  (sample_in)
);

// File: tb/test_pin_cfg_settle_seq.sv
`timescale 1ns/1ps
module test_pin_cfg_settle_seq;

  localparam int DW = 20;
  localparam int PF = 60;
  localparam int PS = 100;
  localparam int NF = 2;
  localparam int NS = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          filt = 1'b0;
  logic          gain = 1'b0;
  logic [DW-1:0] sample_in = '0;
  logic          rd_bit = 1'b0;
  logic          rdy_dout, conv_done, data_valid, gain_unity;
  logic [DW-1:0] data_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  logic [DW-1:0] cur = 20'h1A5C3;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pin_cfg_settle_seq i_pin_cfg_settle_seq (
    .clk (clk), .rst_n (rst_n), .filt_sel_pin (filt), .gain_sel_pin (gain),
    .sample_in (sample_in), .rd_bit (rd_bit), .rdy_dout (rdy_dout),
    .conv_done (conv_done), .data_valid (data_valid), .data_out (data_out),
    .gain_unity (gain_unity)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // one clock; at each conversion verify the load (R8), then vary the sample
  task automatic step();
    @(negedge clk);
    if (conv_done) begin
      chk("R8 data load", data_out, cur);
      cur = cur * 5 + 20'h00D31;
      sample_in = cur;
    end
  endtask

  // from pin edge applied at cycle c0: restart, settle, ready window, next period
  task automatic measure(input string req, input int n, input int p, input int c0);
    int convs = 0;
    int early = 0;
    int v;
    while (!data_valid && cyc < c0 + 3 + n * p + 10) begin
      step();
      if (cyc == c0 + 3) chk("R5/R6 rdy high after edge", rdy_dout, 1);
      if (cyc >= c0 + 3 && !data_valid && rdy_dout !== 1'b1) early++;
      if (conv_done && !data_valid) convs++;
    end
    v = cyc;
    chk({req, " first valid cycle"}, v, c0 + 3 + n * p);
    chk("R8 settling conversions", convs, n - 1);
    chk("R10 no ready during settle", early, 0);
    chk("R9 rdy low with valid", rdy_dout, 0);
    step();
    chk("R9 valid one clock", data_valid, 0);
    while (cyc < v + p - 2) step();
    chk("R9 rdy still low", rdy_dout, 0);
    step();
    chk("R9 rdy high before next", rdy_dout, 1);
    step();
    chk("R2 next conversion period", {30'd0, conv_done, data_valid}, 2'b11);
  endtask

  initial begin
    int c0;
    int c1;
    logic [DW-1:0] word;
    sample_in = cur;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdy", rdy_dout, 1);
    chk("R1 valid", data_valid, 0);
    chk("R1 conv", conv_done, 0);
    chk("R1 data", data_out, 0);
    rst_n = 1'b1;
    c0 = cyc;
    while (!data_valid && cyc < c0 + 2 * PF + 10) step();
    chk("R4 first valid after reset", cyc, c0 + NF * PF);
    chk("R7 gain status low", gain_unity, 0);

    // R11 serial read of a fresh result
    word = data_out;
    chk("R11 rdy low before read", rdy_dout, 0);
    for (int i = 0; i < DW; i++) begin
      rd_bit = 1'b1;
      step();
      rd_bit = 1'b0;
      chk("R11 serial bit", rdy_dout, word[DW-1-i]);
    end

    // R3: filter rise -> slow
    step(); c0 = cyc; filt = 1'b1;
    measure("R3 filt rise", NS, PS, c0);
    // R6 gain rise with slow filter
    step(); c0 = cyc; gain = 1'b1;
    step(); step(); step();
    chk("R7 gain status high", gain_unity, 1);
    measure("R6 gain rise slow", NS, PS, c0);
    // R4 filter fall -> fast
    step(); c0 = cyc; filt = 1'b0;
    measure("R4 filt fall", NF, PF, c0);
    // R6 gain fall with fast filter
    step(); c0 = cyc; gain = 1'b0;
    measure("R6 gain fall fast", NF, PF, c0);
    chk("R7 gain status low again", gain_unity, 0);

    // R10 reads during hold-off return ones
    step(); c0 = cyc; filt = 1'b1;
    repeat (5) step();
    for (int i = 0; i < 8; i++) begin
      rd_bit = 1'b1;
      step();
      rd_bit = 1'b0;
      chk("R10 read during settle", rdy_dout, 1);
    end
    measure("R3 slow after reads", NS, PS, c0);

    // R12 edge mid-settle restarts the count
    step(); c0 = cyc; gain = 1'b1;
    while (cyc < c0 + PS + 20) begin
      step();
      if (data_valid) chk("R12 no early valid", data_valid, 0);
    end
    c1 = cyc; gain = 1'b0;
    measure("R12 mid-settle restart", NS, PS, c1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule